// File: doc/BRIEF.md
# Burst Column Address and Read Latency Sequencer

This block sits between the command decoder and the column datapath of a synchronous graphics memory. A stored mode word sets the burst length, the address ordering and the read latency. Once a read or write command arrives with an 8-bit start column, the block steps through the burst's column addresses one per cycle. It flags each beat as a read or a write column and marks the final beat. For reads it also produces the delayed data-valid window at the programmed latency, together with a per-byte output enable.

A new read or write replaces the running burst at once. A burst-terminate or precharge strobe stops column generation. Read data already in flight still drains at the programmed latency, so the read output ends a latency's worth of cycles after the stop. Byte masks act on the output enable two cycles after they are sampled. A write command silences the read output two cycles later, which keeps the shared data bus free for the write.

Top module: `burst_seq`

## Requirements
- R1: The mode word is decoded as follows. Bits [2:0] give the length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page of 256; any other code gives 1. Bit 3 picks the order, 0 for sequential and 1 for interleaved, but a full page always runs sequentially. Bits [6:4] give the latency: 010 gives 2 and any other value gives 3. A word written in cycle t governs commands from cycle t+1 onward. After reset the mode is length 1, sequential, latency 3.
- R2: A read or write sampled in cycle t presents beat k in cycle t+1+k, with col_rd or col_wr high. Beat 0 always carries start_col, and col_rd and col_wr are never high together.
- R3: In sequential order, beat k of a length-L burst keeps the start column's upper bits. Its low log2(L) bits equal (start + k) mod L.
- R4: In interleaved order, beat k keeps the upper bits of the start column. Its low bits equal the start column's low bits XOR k; for example, a start of 1 at length 4 gives 1, 0, 3, 2.
- R5: A full-page burst steps through columns in sequence, wrapping from 255 to 0. It runs until it is replaced or stopped, and it never raises burst_done.
- R6: burst_done is high in the cycle that presents the final beat of a fixed-length burst. In the next cycle col_rd and col_wr are low, unless a new command arrived.
- R7: A read or write in any cycle restarts the sequence at beat 0 in the next cycle, discarding the rest of the old burst. When cmd_rd and cmd_wr are both high, the write is taken.
- R8: When cmd_term or cmd_pre is high with no read or write, no column beat is presented from the next cycle on. With no burst running, the stop strobe has no effect.
- R9: A read beat presented in cycle c raises rd_valid in cycle c+CL-1, so the first word arrives CL cycles after the read command. After a stop in cycle p, the last read word appears in cycle p+CL-1.
- R10: dq_oe[b] is high only when rd_valid is high and byte_mask[b] was low two cycles earlier. Byte b covers data bits 8b+7..8b.
- R11: A write in cycle w forces rd_valid and all of dq_oe low in cycle w+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load mode_word into the mode register |
| mode_word | input | 7 | Length code [2:0], order [3], latency code [6:4] |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_term | input | 1 | Burst-terminate strobe |
| cmd_pre | input | 1 | Precharge strobe (stops the burst) |
| start_col | input | COL_W | Start column for a read or write |
| byte_mask | input | NBYTES | Per-byte output disable, acts two cycles later |
| col_addr | output | COL_W | Column address of the current beat |
| col_rd | output | 1 | Current beat is a read column |
| col_wr | output | 1 | Current beat is a write column |
| burst_done | output | 1 | Current beat is the last of a fixed-length burst |
| rd_valid | output | 1 | Read data word on the bus this cycle |
| dq_oe | output | NBYTES | Per-byte read output enable |

## Verification
Some properties are checked on every cycle. Beat 0 of any accepted command carries the start column. A stop or a final beat leaves no column beat behind it. Read and write flags never overlap. Read-valid traces back to a read column one or two cycles earlier. A write silences the read output two cycles later, and a sampled mask clears its byte enables two cycles on. Other behaviours need the bench's scenarios, which compare against a schedule model on every clock. These are the full address orderings for each length and type, the wrap of a full page, and the decode of reserved mode codes. They also include the exact drain window of read data after a terminate or precharge at both latencies, and the interplay of overlapping interruptions.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Kind of burst the column engine is stepping through
    typedef enum logic [1:0] {
        XFER_IDLE = 2'd0,
        XFER_RD   = 2'd1,
        XFER_WR   = 2'd2
    } xfer_e;

    // Field positions inside the mode word
    localparam int LEN_LSB = 0;
    localparam int ORD_BIT = 3;
    localparam int LAT_LSB = 4;

    localparam logic [2:0] LEN_CODE_2    = 3'b001;
    localparam logic [2:0] LEN_CODE_4    = 3'b010;
    localparam logic [2:0] LEN_CODE_8    = 3'b011;
    localparam logic [2:0] LEN_CODE_PAGE = 3'b111;
    localparam logic [2:0] LAT_CODE_2    = 3'b010;
    localparam logic [2:0] LAT_CODE_3    = 3'b011;

endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [6:0]       mode_word,
    output logic [COL_W-1:0] len_mask,
    output logic             page,
    output logic             ileave,
    output logic             cl3
);

    typedef struct packed {
        logic [2:0] len_code;
        logic       order;
        logic [2:0] lat_code;
    } mode_t;

    mode_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (mode_wr) begin
            m_d.len_code = mode_word[LEN_LSB +: 3];
            m_d.order    = mode_word[ORD_BIT];
            m_d.lat_code = mode_word[LAT_LSB +: 3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{len_code: 3'b000, order: 1'b0, lat_code: LAT_CODE_3};
        end else begin
            m_q <= m_d;
        end
    end

    // Length code to a mask of the low column bits that wrap
    always_comb begin
        case (m_q.len_code)
            LEN_CODE_2:    len_mask = COL_W'(1);
            LEN_CODE_4:    len_mask = COL_W'(3);
            LEN_CODE_8:    len_mask = COL_W'(7);
            LEN_CODE_PAGE: len_mask = '1;
            default:       len_mask = '0;
        endcase
        page   = (m_q.len_code == LEN_CODE_PAGE);
        ileave = m_q.order & ~page;
        cl3    = (m_q.lat_code != LAT_CODE_2);
    end

endmodule

// File: rtl/bseq_col_engine.sv
module bseq_col_engine
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic             cmd_stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] len_mask,
    input  logic             page,
    input  logic             ileave,
    output logic [COL_W-1:0] col_addr,
    output logic             col_rd,
    output logic             col_wr,
    output logic             last_beat
);

    typedef struct packed {
        xfer_e            kind;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] lmask;
        logic             page;
        logic             il;
    } eng_t;

    eng_t e_d, e_q;
    logic [COL_W-1:0] offset;

    // Final beat of a fixed-length burst: beat count reaches length-1
    assign last_beat = (e_q.kind != XFER_IDLE) && !e_q.page && (e_q.beat == e_q.lmask);

    always_comb begin
        e_d = e_q;
        if (cmd_rd || cmd_wr) begin
            e_d.kind  = cmd_wr ? XFER_WR : XFER_RD;
            e_d.base  = start_col;
            e_d.beat  = '0;
            e_d.lmask = len_mask;
            e_d.page  = page;
            e_d.il    = ileave;
        end else if (cmd_stop) begin
            e_d.kind = XFER_IDLE;
        end else if (e_q.kind != XFER_IDLE) begin
            if (last_beat) begin
                e_d.kind = XFER_IDLE;
            end else begin
                e_d.beat = e_q.beat + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{kind: XFER_IDLE, base: '0, beat: '0, lmask: '0, page: 1'b0, il: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    always_comb begin
        offset   = e_q.il ? (e_q.base ^ e_q.beat) : (e_q.base + e_q.beat);
        col_addr = (e_q.base & ~e_q.lmask) | (offset & e_q.lmask);
        col_rd   = (e_q.kind == XFER_RD);
        col_wr   = (e_q.kind == XFER_WR);
    end

endmodule

// File: rtl/bseq_rd_pipe.sv
module bseq_rd_pipe #(
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_rd,
    input  logic              cmd_wr,
    input  logic              cl3,
    input  logic [NBYTES-1:0] byte_mask,
    output logic              rd_valid,
    output logic [NBYTES-1:0] dq_oe
);

    localparam int DEPTH = 2;

    typedef struct packed {
        logic [DEPTH-1:0]  dv;
        logic [DEPTH-1:0]  wkill;
        logic [NBYTES-1:0] msk1;
        logic [NBYTES-1:0] msk2;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.dv    = {p_q.dv[DEPTH-2:0], col_rd};
        p_d.wkill = {p_q.wkill[DEPTH-2:0], cmd_wr};
        p_d.msk1  = byte_mask;
        p_d.msk2  = p_q.msk1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    // Latency 2 taps one stage behind the column, latency 3 taps two
    always_comb begin
        rd_valid = (cl3 ? p_q.dv[1] : p_q.dv[0]) & ~p_q.wkill[DEPTH-1];
        dq_oe    = {NBYTES{rd_valid}} & ~p_q.msk2;
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int COL_W  = 8,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [6:0]        mode_word,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic              cmd_term,
    input  logic              cmd_pre,
    input  logic [COL_W-1:0]  start_col,
    input  logic [NBYTES-1:0] byte_mask,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_rd,
    output logic              col_wr,
    output logic              burst_done,
    output logic              rd_valid,
    output logic [NBYTES-1:0] dq_oe
);

    logic [COL_W-1:0] len_mask;
    logic             page;
    logic             ileave;
    logic             cl3;
    logic             cmd_stop;

    assign cmd_stop = cmd_term | cmd_pre;

    bseq_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_word (mode_word),
        .len_mask  (len_mask),
        .page      (page),
        .ileave    (ileave),
        .cl3       (cl3)
    );

    bseq_col_engine #(.COL_W(COL_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .cmd_stop  (cmd_stop),
        .start_col (start_col),
        .len_mask  (len_mask),
        .page      (page),
        .ileave    (ileave),
        .col_addr  (col_addr),
        .col_rd    (col_rd),
        .col_wr    (col_wr),
        .last_beat (burst_done)
    );

    bseq_rd_pipe #(.NBYTES(NBYTES)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_rd    (col_rd),
        .cmd_wr    (cmd_wr),
        .cl3       (cl3),
        .byte_mask (byte_mask),
        .rd_valid  (rd_valid),
        .dq_oe     (dq_oe)
    );

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int COL_W  = 8,
    parameter int NBYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_rd,
    input logic              cmd_wr,
    input logic              cmd_term,
    input logic              cmd_pre,
    input logic [COL_W-1:0]  start_col,
    input logic [NBYTES-1:0] byte_mask,
    input logic [COL_W-1:0]  col_addr,
    input logic              col_rd,
    input logic              col_wr,
    input logic              burst_done,
    input logic              rd_valid,
    input logic [NBYTES-1:0] dq_oe
);

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_rd && col_wr)); // R2

    AST_RD_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && !cmd_wr) |=> (col_rd && col_addr == $past(start_col))); // R2

    AST_WR_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (col_wr && col_addr == $past(start_col))); // R7

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && !cmd_rd && !cmd_wr) |=> (!col_rd && !col_wr)); // R6

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_term || cmd_pre) && !cmd_rd && !cmd_wr) |=> (!col_rd && !col_wr)); // R8

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(col_rd) || $past(col_rd, 2))); // R9

    AST_MASK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe & $past(byte_mask, 2)) == '0); // R10

    AST_WR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_wr, 2) |-> (!rd_valid && dq_oe == '0)); // R11

endmodule

bind burst_seq burst_seq_chk #(.COL_W(COL_W), .NBYTES(NBYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_rd     (cmd_rd),
    .cmd_wr     (cmd_wr),
    .cmd_term   (cmd_term),
    .cmd_pre    (cmd_pre),
    .start_col  (start_col),
    .byte_mask  (byte_mask),
    .col_addr   (col_addr),
    .col_rd     (col_rd),
    .col_wr     (col_wr),
    .burst_done (burst_done),
    .rd_valid   (rd_valid),
    .dq_oe      (dq_oe)
);

// File: tb/tb_burst_seq.sv
module tb_burst_seq;

    localparam int MAXC = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [6:0] mode_word = '0;
    logic       cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_term = 1'b0, cmd_pre = 1'b0;
    logic [7:0] start_col = '0;
    logic [3:0] byte_mask = '0;
    logic [7:0] col_addr;
    logic       col_rd, col_wr, burst_done, rd_valid;
    logic [3:0] dq_oe;

    burst_seq #(.COL_W(8), .NBYTES(4)) dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_word(mode_word),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_term(cmd_term), .cmd_pre(cmd_pre),
        .start_col(start_col), .byte_mask(byte_mask), .col_addr(col_addr),
        .col_rd(col_rd), .col_wr(col_wr), .burst_done(burst_done),
        .rd_valid(rd_valid), .dq_oe(dq_oe)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Schedule model: expected outputs per absolute cycle
    int       exp_kind [MAXC];
    int       exp_col  [MAXC];
    bit       exp_done [MAXC];
    bit       exp_rdv  [MAXC];
    bit       exp_kill [MAXC];
    bit [3:0] exp_mask [MAXC];

    int    m_len = 1, m_cl = 3;
    bit    m_il = 0, m_page = 0;
    int    n_chk = 0, n_bad = 0;
    bit    finished = 0;
    string tag = "R1";

    function automatic int ref_addr(int s, int k, int len, bit il);
        int lo = s % len;
        int blk = s - lo;
        if (il) return blk + ((lo ^ k) % len);
        return blk + ((lo + k) % len);
    endfunction

    function automatic void clear_after(int t);
        for (int n = t + 1; n < MAXC; n++) begin
            exp_kind[n] = 0;
            exp_done[n] = 0;
        end
        for (int n = t + m_cl; n < MAXC; n++) exp_rdv[n] = 0;
    endfunction

    function automatic void model_cmd(int t, bit rd, bit wr, bit stp, int col, bit [3:0] msk);
        int len, hz, n;
        bit il;
        if (rd || wr) begin
            clear_after(t);
            len = m_page ? 256 : m_len;
            il  = m_il && !m_page;
            hz  = m_page ? 600 : len;
            for (int k = 0; k < hz; k++) begin
                n = t + 1 + k;
                if (n < MAXC) begin
                    exp_kind[n] = wr ? 2 : 1;
                    exp_col[n]  = ref_addr(col, k, len, il);
                    if (!wr && n + m_cl - 1 < MAXC) exp_rdv[n + m_cl - 1] = 1;
                end
            end
            if (!m_page && t + len < MAXC) exp_done[t + len] = 1;
        end else if (stp) begin
            clear_after(t);
        end
        if (wr && t + 2 < MAXC) exp_kill[t + 2] = 1;
        if (t + 2 < MAXC) exp_mask[t + 2] = msk;
    endfunction

    function automatic void model_mode(bit [6:0] w);
        case (w[2:0])
            3'b001: m_len = 2;
            3'b010: m_len = 4;
            3'b011: m_len = 8;
            default: m_len = 1;
        endcase
        m_page = (w[2:0] == 3'b111);
        m_il   = w[3];
        m_cl   = (w[6:4] == 3'b010) ? 2 : 3;
    endfunction

    task automatic drive(input bit rd, input bit wr, input bit st, input bit pr,
                         input int col, input bit [3:0] msk, input bit mw, input bit [6:0] mword);
        int t;
        @(negedge clk);
        t = cyc;
        cmd_rd = rd; cmd_wr = wr; cmd_term = st; cmd_pre = pr;
        start_col = col[7:0]; byte_mask = msk; mode_wr = mw; mode_word = mword;
        model_cmd(t, rd, wr, st | pr, col, msk);
        if (mw) model_mode(mword);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 4'h0, 0, 7'h0);
    endtask
    task automatic rd_cmd(input int c);  drive(1, 0, 0, 0, c, 4'h0, 0, 7'h0); endtask
    task automatic wr_cmd(input int c);  drive(0, 1, 0, 0, c, 4'h0, 0, 7'h0); endtask
    task automatic term_cmd();           drive(0, 0, 1, 0, 0, 4'h0, 0, 7'h0); endtask
    task automatic pre_cmd();            drive(0, 0, 0, 1, 0, 4'h0, 0, 7'h0); endtask
    task automatic mask_only(input bit [3:0] m); drive(0, 0, 0, 0, 0, m, 0, 7'h0); endtask
    task automatic set_mode(input bit [2:0] lat, input bit ord, input bit [2:0] len);
        drive(0, 0, 0, 0, 0, 4'h0, 1, {lat, ord, len});
        idle(1);
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%s) %s cycle %0d: actual=%0d expected=%0d", req, tag, what, cyc, act, expv);
        end
    endtask

    // Compare every output on every cycle, mid-cycle
    always @(negedge clk) begin
        if (!finished && cyc >= 1 && cyc < MAXC) begin
            automatic int  ek = exp_kind[cyc];
            automatic bit  ev = exp_rdv[cyc] && !exp_kill[cyc];
            automatic bit [3:0] eo = ev ? ~exp_mask[cyc] : 4'h0;
            chk(col_rd == (ek == 1), "R2", "col_rd", int'(col_rd), int'(ek == 1));
            chk(col_wr == (ek == 2), "R2", "col_wr", int'(col_wr), int'(ek == 2));
            if (ek != 0) chk(int'(col_addr) == exp_col[cyc], tag, "col_addr", int'(col_addr), exp_col[cyc]);
            chk(burst_done == exp_done[cyc], "R6", "burst_done", int'(burst_done), int'(exp_done[cyc]));
            chk(rd_valid == ev, "R9", "rd_valid", int'(rd_valid), int'(ev));
            chk(dq_oe == eo, "R10", "dq_oe", int'(dq_oe), int'(eo));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state and default mode (length 1, latency 3)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        rd_cmd(5); idle(6);
        wr_cmd(9); idle(4);

        // R3: sequential length 4 latency 2, wrap in aligned block
        tag = "R3";
        set_mode(3'b010, 1'b0, 3'b010);
        rd_cmd(1); idle(6);
        wr_cmd(6); idle(6);
        set_mode(3'b011, 1'b0, 3'b011);
        rd_cmd(13); idle(12);
        set_mode(3'b011, 1'b0, 3'b001);
        rd_cmd(7); idle(5);

        // R4: interleaved orders
        tag = "R4";
        set_mode(3'b010, 1'b1, 3'b010);
        rd_cmd(1); idle(6);
        set_mode(3'b011, 1'b1, 3'b011);
        rd_cmd(5); idle(12);
        wr_cmd(34); idle(10);

        // R5 and R8: full page (order bit ignored), wrap past 255, then terminate
        tag = "R5";
        set_mode(3'b011, 1'b1, 3'b111);
        rd_cmd(250); idle(20);
        term_cmd(); idle(6);
        set_mode(3'b010, 1'b0, 3'b111);
        wr_cmd(254); idle(5);
        pre_cmd(); idle(5);

        // R7: read replaced by read, then by write; both strobes together
        tag = "R7";
        set_mode(3'b011, 1'b0, 3'b011);
        rd_cmd(0); idle(1);
        rd_cmd(18); rd_cmd(40); idle(2);
        wr_cmd(3); idle(10);
        drive(1, 1, 0, 0, 77, 4'h0, 0, 7'h0); idle(10);

        // R11: write right after a read at latency 3 and latency 2
        tag = "R11";
        rd_cmd(8); wr_cmd(20); idle(10);
        set_mode(3'b010, 1'b0, 3'b010);
        rd_cmd(8); idle(1); wr_cmd(60); idle(8);

        // R8 and R9: stops cut read data after the latency
        tag = "R8";
        set_mode(3'b011, 1'b0, 3'b011);
        rd_cmd(16); idle(1); term_cmd(); idle(8);
        rd_cmd(16); pre_cmd(); idle(8);
        set_mode(3'b010, 1'b0, 3'b011);
        rd_cmd(24); idle(2); pre_cmd(); idle(8);
        wr_cmd(24); term_cmd(); idle(6);
        term_cmd(); pre_cmd(); idle(3);

        // R10: byte masks during a read burst and while idle
        tag = "R10";
        set_mode(3'b011, 1'b0, 3'b011);
        drive(1, 0, 0, 0, 32, 4'h1, 0, 7'h0);
        mask_only(4'h0); mask_only(4'hA); mask_only(4'hF);
        mask_only(4'h4); mask_only(4'h0); mask_only(4'h8);
        idle(8);
        mask_only(4'hF); idle(4);

        // R1: reserved codes decode to length 1 and latency 3
        tag = "R1";
        set_mode(3'b000, 1'b0, 3'b100);
        rd_cmd(90); idle(6);
        set_mode(3'b111, 1'b1, 3'b110);
        rd_cmd(91); idle(6);
        // mode word takes effect for a command in the very next cycle
        drive(0, 0, 0, 0, 0, 4'h0, 1, {3'b010, 1'b0, 3'b001});
        rd_cmd(3); idle(6);

        idle(4);
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule